// File: doc/BRIEF.md
# CCD Line Readout Timing Generator

This block sequences the digital control waveforms needed to move one line of charge out of a frame-transfer CCD. It runs from a master clock at six times the pixel rate, so every pixel period is cut into six sub-steps on which the register clock edges fall. When a line is requested, a fixed line-shift window runs first. The horizontal register clocks are held in a parked state, a start-stop level is raised, and, for frames in progress, the four-phase storage clocks step the charge down by one line. The readout section follows and clocks out every register cell. The three register clocks are spaced a third of a pixel apart, the summing gate follows the last register phase, and one reset-gate pulse is issued per pixel.

For each pixel that leaves the register, a one-cycle valid strobe is issued together with the reset-gate pulse and a two-bit tag naming the cell's region. The downstream digitiser uses these to pick active samples and black references. Line requests are accepted only when no line is running. If a request is present on the last cycle of a line, the next line starts with no gap.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is held, the outputs are: start-stop high, register clocks parked at C1=1 C2=0 C3=1 (hclk_o=3'b101), reset gate and valid low, region tag 0, and storage clocks vclk_o=4'b1101.
- R2: A request accepted in idle starts a line of 1184 pixel periods (7104 master cycles). The first 105 periods (630 cycles) are the shift window with start-stop high. The remaining 1079 periods have start-stop low. A request present in the last cycle of a line starts the next line on the following cycle.
- R3: In readout the sub-step counter starts at 0 at each pixel. hclk_o[0] (C1) is high in sub-steps 0-2, hclk_o[1] (C2) in 2-4 and hclk_o[2] (C3) in 4, 5 and 0. Outside readout the clocks hold the sub-step 0 pattern 3'b101.
- R4: The reset gate is high for exactly the sub-step 0 cycle of each readout pixel. The summing gate always equals C3.
- R5: pix_valid_o coincides with every reset-gate pulse. region_o names the current cell in the order dummy, black, timing, active, timing, black, encoded dummy=0, black=1, timing=2, active=3, and it is 0 outside readout.
- R6: Every line yields 7 dummy, 40 black, 8 timing and 1024 active valid strobes, with readout lasting 6474 master cycles.
- R7: A line request arriving while a line is in progress has no effect on any output.
- R8: The storage clocks follow a 3-bit state s. Phase p (vclk_o[p]) is high when (s-2p) mod 8 < 5. When frame_active_i was high at acceptance, s advances by one at shift-window pixel periods 39, 44, 49 and 54 (4 steps of 5 periods from period 34). Otherwise s does not change during that line.
- R9: The storage clocks stay static during readout and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, six times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Line request, sampled when idle or on the last line cycle |
| frame_active_i | input | 1 | Enables storage clock stepping, sampled at line acceptance |
| hclk_o | output | 3 | Horizontal register clocks, bit 0 = C1 |
| sg_o | output | 1 | Summing gate |
| rg_o | output | 1 | Reset gate |
| ssc_o | output | 1 | Start-stop: high while register clocks are halted |
| vclk_o | output | 4 | Storage section clocks, bit p = phase p+1 |
| pix_valid_o | output | 1 | One-cycle strobe per output pixel |
| region_o | output | 2 | Region tag of the current pixel |

## Verification
The bench compares every output in every cycle against an independent cycle-count model. It aims at the edges: the hand-over from shift window to readout, the region boundaries at pixels 7, 27, 31, 1055 and 1059, and lines run back to back with the request held high. A design that is off by one at a region boundary would miscount black or timing cells. A design that drops the back-to-back path would insert an idle cycle and stretch the line period past 7104 cycles. Random request pulses in mid-line and frame-active toggles after acceptance expose a design that restarts a line or re-samples the vertical enable: the readout would be cut short or the storage clocks would step when they should not.

// File: rtl/ccd_lt_pkg.sv
package ccd_lt_pkg;
  localparam int unsigned SUB_STEPS = 6;

  typedef enum logic [1:0] {
    REG_DUMMY  = 2'd0,
    REG_BLACK  = 2'd1,
    REG_TIMING = 2'd2,
    REG_ACTIVE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_READ  = 2'd2
  } line_st_e;
endpackage

// File: rtl/ccd_lt_seq.sv
module ccd_lt_seq
  import ccd_lt_pkg::*;
#(
  parameter int unsigned SHIFT_TP = 105,
  parameter int unsigned READ_TP  = 1079,
  parameter int unsigned TPW      = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           line_start_i,
  input  logic           frame_active_i,
  output line_st_e       state_o,
  output logic [TPW-1:0] tp_o,
  output logic [2:0]     sub_o,
  output logic           vact_o
);
  localparam logic [TPW-1:0] SHIFT_LAST = TPW'(SHIFT_TP - 1);
  localparam logic [TPW-1:0] READ_LAST  = TPW'(READ_TP - 1);
  localparam logic [2:0]     SUB_LAST   = 3'(SUB_STEPS - 1);

  logic last_tp;
  assign last_tp = (state_o == ST_SHIFT) ? (tp_o == SHIFT_LAST) : (tp_o == READ_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      tp_o    <= '0;
      sub_o   <= '0;
      vact_o  <= 1'b0;
    end else begin
      case (state_o)
        ST_IDLE: begin
          if (line_start_i) begin
            state_o <= ST_SHIFT;
            tp_o    <= '0;
            sub_o   <= '0;
            vact_o  <= frame_active_i;
          end
        end
        default: begin
          if (sub_o == SUB_LAST) begin
            sub_o <= '0;
            if (last_tp) begin
              tp_o <= '0;
              if (state_o == ST_SHIFT) begin
                state_o <= ST_READ;
              end else if (line_start_i) begin
                state_o <= ST_SHIFT;
                vact_o  <= frame_active_i;
              end else begin
                state_o <= ST_IDLE;
              end
            end else begin
              tp_o <= tp_o + 1'b1;
            end
          end else begin
            sub_o <= sub_o + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ccd_lt_hclk.sv
module ccd_lt_hclk
  import ccd_lt_pkg::*;
#(
  parameter int unsigned PHASES = 3
) (
  input  logic              reading_i,
  input  logic [2:0]        sub_i,
  output logic [PHASES-1:0] hclk_o,
  output logic              sg_o,
  output logic              rg_o
);
  localparam int unsigned SPACING = SUB_STEPS / PHASES;
  localparam int unsigned HIGH_W  = SUB_STEPS / 2;

  logic [2:0] eff_sub;
  assign eff_sub = reading_i ? sub_i : 3'd0;  // parked at sub-step 0 pattern

  for (genvar i = 0; i < PHASES; i++) begin : g_ph
    localparam int unsigned OFS = i * SPACING;
    int unsigned rel;
    always_comb begin
      rel       = (32'(eff_sub) + SUB_STEPS - OFS) % SUB_STEPS;
      hclk_o[i] = (rel < HIGH_W);
    end
  end

  assign sg_o = hclk_o[PHASES-1];
  assign rg_o = reading_i && (sub_i == 3'd0);
endmodule

// File: rtl/ccd_lt_region.sv
module ccd_lt_region
  import ccd_lt_pkg::*;
#(
  parameter int unsigned N_DUMMY  = 7,
  parameter int unsigned N_BLACK  = 20,
  parameter int unsigned N_TIMING = 4,
  parameter int unsigned N_ACTIVE = 1024,
  parameter int unsigned TPW      = 11
) (
  input  logic           reading_i,
  input  logic [TPW-1:0] tp_i,
  output region_e        region_o
);
  localparam int unsigned B0 = N_DUMMY;
  localparam int unsigned B1 = B0 + N_BLACK;
  localparam int unsigned B2 = B1 + N_TIMING;
  localparam int unsigned B3 = B2 + N_ACTIVE;
  localparam int unsigned B4 = B3 + N_TIMING;

  always_comb begin
    if (!reading_i)                region_o = REG_DUMMY;
    else if (tp_i < TPW'(B0))      region_o = REG_DUMMY;
    else if (tp_i < TPW'(B1))      region_o = REG_BLACK;
    else if (tp_i < TPW'(B2))      region_o = REG_TIMING;
    else if (tp_i < TPW'(B3))      region_o = REG_ACTIVE;
    else if (tp_i < TPW'(B4))      region_o = REG_TIMING;
    else                           region_o = REG_BLACK;
  end
endmodule

// File: rtl/ccd_lt_vshift.sv
module ccd_lt_vshift #(
  parameter int unsigned VSTART_TP = 34,
  parameter int unsigned VSTEP_TP  = 5,
  parameter int unsigned TPW       = 11,
  parameter int unsigned VPHASES   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [TPW-1:0]     tp_i,
  input  logic               vact_i,
  output logic [VPHASES-1:0] vclk_o
);
  localparam int unsigned VSTATES = 2 * VPHASES;
  localparam int unsigned VHIGH   = (VSTATES * 5) / 8;
  localparam int unsigned VSW     = $clog2(VSTATES);
  localparam int unsigned DW      = $clog2(VSTEP_TP + 1);
  localparam int unsigned WIN_END = VSTART_TP + VPHASES * VSTEP_TP;

  logic [DW-1:0]  vdiv;
  logic [VSW-1:0] vstate;
  logic           in_win;

  assign in_win = (tp_i >= TPW'(VSTART_TP)) && (tp_i < TPW'(WIN_END));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vdiv   <= '0;
      vstate <= '0;
    end else if (step_i && vact_i && in_win) begin
      if (vdiv == DW'(VSTEP_TP - 1)) begin
        vdiv   <= '0;
        vstate <= vstate + 1'b1;
      end else begin
        vdiv <= vdiv + 1'b1;
      end
    end
  end

  for (genvar p = 0; p < VPHASES; p++) begin : g_vph
    int unsigned rel;
    always_comb begin
      rel       = (32'(vstate) + VSTATES - 2 * p) % VSTATES;
      vclk_o[p] = (rel < VHIGH);
    end
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_lt_pkg::*;
#(
  parameter int unsigned N_DUMMY   = 7,
  parameter int unsigned N_BLACK   = 20,
  parameter int unsigned N_TIMING  = 4,
  parameter int unsigned N_ACTIVE  = 1024,
  parameter int unsigned SHIFT_TP  = 105,
  parameter int unsigned VSTART_TP = 34,
  parameter int unsigned VSTEP_TP  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_start_i,
  input  logic       frame_active_i,
  output logic [2:0] hclk_o,
  output logic       sg_o,
  output logic       rg_o,
  output logic       ssc_o,
  output logic [3:0] vclk_o,
  output logic       pix_valid_o,
  output logic [1:0] region_o
);
  localparam int unsigned READ_TP = N_DUMMY + 2 * N_BLACK + 2 * N_TIMING + N_ACTIVE;
  localparam int unsigned MAX_TP  = (READ_TP > SHIFT_TP) ? READ_TP : SHIFT_TP;
  localparam int unsigned TPW     = $clog2(MAX_TP + 1);

  line_st_e       state;
  logic [TPW-1:0] tp;
  logic [2:0]     sub;
  logic           vact;
  logic           reading;
  logic           vstep;
  region_e        region;

  ccd_lt_seq #(.SHIFT_TP(SHIFT_TP), .READ_TP(READ_TP), .TPW(TPW)) u_seq (
    .clk_i, .rst_ni, .line_start_i, .frame_active_i,
    .state_o(state), .tp_o(tp), .sub_o(sub), .vact_o(vact)
  );

  assign reading = (state == ST_READ);
  assign vstep   = (state == ST_SHIFT) && (sub == 3'(SUB_STEPS - 1));

  ccd_lt_hclk #(.PHASES(3)) u_hclk (
    .reading_i(reading), .sub_i(sub), .hclk_o, .sg_o, .rg_o
  );

  ccd_lt_region #(
    .N_DUMMY(N_DUMMY), .N_BLACK(N_BLACK), .N_TIMING(N_TIMING),
    .N_ACTIVE(N_ACTIVE), .TPW(TPW)
  ) u_region (
    .reading_i(reading), .tp_i(tp), .region_o(region)
  );

  ccd_lt_vshift #(
    .VSTART_TP(VSTART_TP), .VSTEP_TP(VSTEP_TP), .TPW(TPW), .VPHASES(4)
  ) u_vshift (
    .clk_i, .rst_ni, .step_i(vstep), .tp_i(tp), .vact_i(vact), .vclk_o
  );

  assign ssc_o       = !reading;
  assign pix_valid_o = reading && (sub == 3'd0);
  assign region_o    = region;
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] hclk_o,
  input logic       sg_o,
  input logic       rg_o,
  input logic       ssc_o,
  input logic [3:0] vclk_o,
  input logic       pix_valid_o,
  input logic [1:0] region_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_hclk_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(hclk_o) == 1) || ($countones(hclk_o) == 2));

  assert_hclk_parked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ssc_o && $past(ssc_o)) |-> $stable(hclk_o));

  assert_rg_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |=> !rg_o);

  assert_rg_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |-> (hclk_o == 3'b101) && sg_o);

  assert_valid_rg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> rg_o && !ssc_o);

  assert_region_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !ssc_o && !pix_valid_o) |-> $stable(region_o));

  assert_vclk_duty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(vclk_o) == 2) || ($countones(vclk_o) == 3));

  assert_vclk_static_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !ssc_o) |-> $stable(vclk_o));
endmodule

bind ccd_line_timer ccd_line_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hclk_o(hclk_o), .sg_o(sg_o), .rg_o(rg_o),
  .ssc_o(ssc_o), .vclk_o(vclk_o), .pix_valid_o(pix_valid_o), .region_o(region_o)
);

// File: tb/tb_ccd_line_timer.sv
`timescale 1ns/1ps
module tb_ccd_line_timer;
  localparam int SHIFT_CYC = 105 * 6;
  localparam int READ_CYC  = 1079 * 6;
  localparam int LINE_CYC  = 1184 * 6;
  localparam int VSTART    = 34;
  localparam int VSTEP     = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_start_i = 1'b0;
  logic       frame_active_i = 1'b0;
  logic [2:0] hclk_o;
  logic       sg_o, rg_o, ssc_o, pix_valid_o;
  logic [3:0] vclk_o;
  logic [1:0] region_o;

  ccd_line_timer dut (
    .clk_i, .rst_ni, .line_start_i, .frame_active_i,
    .hclk_o, .sg_o, .rg_o, .ssc_o, .vclk_o, .pix_valid_o, .region_o
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  bit btb_mode = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] hpat(input int s);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = (((s + 6 - 2 * i) % 6) < 3);
    return r;
  endfunction

  function automatic logic [3:0] vpat(input int s);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) r[p] = ((((s - 2 * p) % 8) + 8) % 8) < 5;
    return r;
  endfunction

  function automatic int reg_of(input int j);
    if (j < 7)    return 0;
    if (j < 27)   return 1;
    if (j < 31)   return 2;
    if (j < 1055) return 3;
    if (j < 1059) return 2;
    return 1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // cycle model and per-cycle comparison
  bit m_busy = 1'b0;
  int m_k = 0;
  bit m_vact = 1'b0;
  int m_vs = 0;
  bit ls_seen = 1'b0;
  bit fa_seen = 1'b0;
  int ncyc = 0;
  int cnt[4];
  bit prev_ssc = 1'b1;
  int fall_cyc = 0;
  int last_fall = 0;
  int btb_falls = 0;

  always @(negedge clk_i) begin
    if (mon_en && !done) begin
      ncyc++;
      if (m_busy) begin
        m_k++;
        if (m_k == LINE_CYC) begin
          if (ls_seen) begin m_k = 0; m_vact = fa_seen; end
          else m_busy = 1'b0;
        end
      end else if (ls_seen) begin
        m_busy = 1'b1; m_k = 0; m_vact = fa_seen;
      end
      if (m_busy && m_vact)
        for (int m = 1; m <= 4; m++)
          if (m_k == 6 * (VSTART + m * VSTEP)) m_vs = (m_vs + 1) % 8;

      begin
        bit rd;
        int sb;
        logic [2:0] eh;
        int er;
        rd = m_busy && (m_k >= SHIFT_CYC);
        sb = rd ? (m_k - SHIFT_CYC) % 6 : 0;
        eh = hpat(sb);
        er = rd ? reg_of((m_k - SHIFT_CYC) / 6) : 0;
        chk(ssc_o == !rd, "R2 start-stop", ssc_o, !rd);       // R7 covered: model ignores busy requests
        chk(hclk_o == eh, "R3 register clocks", hclk_o, eh);
        chk(rg_o == (rd && sb == 0), "R4 reset gate", rg_o, rd && sb == 0);
        chk(sg_o == eh[2], "R4 summing gate", sg_o, eh[2]);
        chk(pix_valid_o == (rd && sb == 0), "R5 valid", pix_valid_o, rd && sb == 0);
        chk(int'(region_o) == er, "R5 region", region_o, er);
        chk(vclk_o == vpat(m_vs), "R8 storage clocks", vclk_o, vpat(m_vs));
      end

      if (pix_valid_o) cnt[region_o]++;
      if (prev_ssc && !ssc_o) begin
        fall_cyc = ncyc;
        if (btb_mode) begin
          if (btb_falls > 0) chk(ncyc - last_fall == LINE_CYC, "R2 back-to-back period", ncyc - last_fall, LINE_CYC);
          btb_falls++;
        end else btb_falls = 0;
        last_fall = ncyc;
      end
      if (!prev_ssc && ssc_o) begin
        chk(ncyc - fall_cyc == READ_CYC, "R6 readout length", ncyc - fall_cyc, READ_CYC);
        chk(cnt[0] == 7, "R6 dummy count", cnt[0], 7);
        chk(cnt[1] == 40, "R6 black count", cnt[1], 40);
        chk(cnt[2] == 8, "R6 timing count", cnt[2], 8);
        chk(cnt[3] == 1024, "R6 active count", cnt[3], 1024);
        for (int i = 0; i < 4; i++) cnt[i] = 0;
      end
      prev_ssc = ssc_o;
      ls_seen = line_start_i;
      fa_seen = frame_active_i;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk_i) begin
    wd++;
    if (wd > 190000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
      summary();
    end
  end

  // one line with spurious mid-line requests (R7) and frame_active toggles
  task automatic run_line(input bit fa, input int gap);
    int used;
    frame_active_i = fa;
    line_start_i = 1'b1;
    tick(1);
    line_start_i = 1'b0;
    used = 1;
    for (int s = 0; s < 3; s++) begin
      int w;
      w = 50 + int'($urandom % 2000);
      tick(w);
      line_start_i = 1'b1;
      frame_active_i = ~frame_active_i;
      tick(1);
      line_start_i = 1'b0;
      used += w + 1;
    end
    tick(LINE_CYC - used + 2 + gap);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    tick(3);
    // R1 reset state
    chk(ssc_o == 1'b1, "R1 start-stop", ssc_o, 1);
    chk(hclk_o == 3'b101, "R1 register clocks", hclk_o, 5);
    chk(rg_o == 1'b0 && pix_valid_o == 1'b0, "R1 reset gate/valid", rg_o, 0);
    chk(region_o == 2'd0, "R1 region", region_o, 0);
    chk(vclk_o == 4'b1101, "R1 storage clocks", vclk_o, 13);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    mon_en = 1'b1;
    tick(5);

    // directed: frame active line, then frame inactive line (R8)
    run_line(1'b1, 4);
    run_line(1'b0, 9);

    // directed: back-to-back lines with request held (R2)
    frame_active_i = 1'b1;
    btb_mode = 1'b1;
    line_start_i = 1'b1;
    tick(3 * LINE_CYC - 10);
    line_start_i = 1'b0;
    btb_mode = 1'b0;
    tick(40);

    // random lines
    for (int n = 0; n < 3; n++) begin
      bit fa;
      fa = 1'($urandom % 2);
      run_line(fa, int'($urandom % 30));
    end
    tick(20);
    summary();
  end
endmodule